// File: doc/BRIEF.md
# Packet-to-Flit DMA Channel

This block moves one packet at a time between a processing element and a single virtual queue of a network router. In send mode it takes a flow ID and a length, places a head flit in front of the payload and pushes the flits into the downstream queue. It pushes several flits in one cycle, up to a fixed number of lanes, and never more than the queue has room for. The payload words are read through a simple combinational read port: the channel gives the index of the first word it needs, and the source returns that word and the words after it, one per lane.

In receive mode the same channel takes flits from the queue. The first flit is taken as the head. Its flow ID and data count are kept, and only the data flits reach the write lanes, packed from lane 0 and tagged with the index of their first word. Each request is accepted only while the channel is idle. A request that arrives during a transfer is refused. A one-cycle done pulse marks the end of each transfer.

Top module: `dmach_channel`

## Requirements
- R1: A request made while the channel is idle is accepted (`reqAccept` high in that same cycle). The channel stores its mode, flow ID and length and moves no flit in the cycle of acceptance. Transfer begins on the next cycle.
- R2: The first flit sent goes out on lane 0. Its bits [FLOW_W+15:16] hold the flow ID and its bits [15:0] hold the data-flit count, which equals the requested length.
- R3: In send mode, each cycle pushes n = min(BW_FLITS, freeSlots, flits still to send) flits on lanes 0..n-1, in packet order, with `pushValid` bit k set for lane k. Data word i is read through `dataIdx`/`rdData`, and lane j of `rdData` is the word at index `dataIdx`+j.
- R4: A request made while a transfer is in progress raises `reqFail` (and not `reqAccept`). It leaves the running transfer unchanged.
- R5: In receive mode, the valid input lanes, packed from lane 0, are consumed in order and marked on `popTake`. The first consumed flit is the head: bits [15:0] give the data count and the upper field gives the flow ID shown on `rxFlow`. Data flits appear packed from lane 0 on `wrValid`/`wrData`, and `dataIdx` gives the word index of lane 0.
- R6: `done` is high for exactly one cycle, the cycle after the last flit of the packet moves. In that cycle the channel is already idle and accepts a new request.
- R7: A packet of length zero is the head flit alone. With at least one free slot (or one offered flit) it completes in one cycle.
- R8: In receive mode, offered flits past the end of the current packet are not taken. They stay for the next receive request, and no flit is taken while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Transfer request |
| reqRecv | input | 1 | Request mode: 1 receive, 0 send |
| reqFlow | input | FLOW_W | Flow ID for a send |
| reqLen | input | 16 | Data-flit count for a send |
| reqAccept | output | 1 | Request taken this cycle |
| reqFail | output | 1 | Request refused, channel busy |
| done | output | 1 | One-cycle completion pulse |
| rxFlow | output | FLOW_W | Flow ID of the last received head |
| dataIdx | output | 16 | Word index of lane 0 for reading or writing |
| rdData | input | BW_FLITS*FLIT_W | Payload words at dataIdx, dataIdx+1, ... |
| pushValid | output | BW_FLITS | Per-lane push strobes to the queue |
| pushData | output | BW_FLITS*FLIT_W | Flits pushed, lane 0 first |
| freeSlots | input | FREE_W | Free slots in the downstream queue |
| popValid | input | BW_FLITS | Flits offered by the queue, packed from lane 0 |
| popData | input | BW_FLITS*FLIT_W | Offered flits |
| popTake | output | BW_FLITS | Lanes consumed this cycle |
| wrValid | output | BW_FLITS | Per-lane write strobes of received data |
| wrData | output | BW_FLITS*FLIT_W | Received data words |

## Verification
Acceptance, refusal and all lane outputs (push, take and write strobes and data) are combinational, so they are due in the same cycle as the inputs that cause them. The bench applies inputs just after the falling edge and compares one time unit later. The reference model updates its queues only after that comparison, which stands for the rising edge. The first flits of a transfer are due one cycle after acceptance, and `done` is due one cycle after the cycle in which the model's queue empties. The model carries that pulse as a pending flag and checks it in the next cycle, together with a new request placed in that same cycle.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int MAX_BW = 4;
  localparam int CNT_W  = 3;
  localparam int LEN_W  = 16;

  typedef struct packed {
    logic             busy;
    logic             isRecv;
    logic             atHead;
    logic [CNT_W-1:0] nMove;
  } dmaStrobe_t;
endpackage

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
#(
  parameter int BW     = 2,
  parameter int FREE_W = 4,
  parameter int FLOW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqRecv,
  input  logic [FLOW_W-1:0] reqFlow,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [FREE_W-1:0] freeSlots,
  input  logic [BW-1:0]     popValid,
  input  logic [FLOW_W-1:0] headFlow,
  input  logic [LEN_W-1:0]  headCnt,
  output logic              reqAccept,
  output logic              reqFail,
  output logic              done,
  output dmaStrobe_t        strb,
  output logic [LEN_W-1:0]  dataIdx,
  output logic [FLOW_W-1:0] flowReg,
  output logic [LEN_W-1:0]  lenReg
);
  localparam int POS_W = LEN_W + 1;

  logic             busy, isRecv, doneR, atHead, lastMove, gap;
  logic [POS_W-1:0] pos, totalNow, remaining;
  logic [CNT_W-1:0] nValid, avail, nMove;

  assign atHead = (pos == '0);

  // count of valid lanes packed from lane 0
  always_comb begin
    nValid = '0;
    gap    = 1'b0;
    for (int k = 0; k < BW; k++) begin
      if (popValid[k] && !gap) nValid = nValid + 1'b1;
      else gap = 1'b1;
    end
  end

  always_comb begin
    if (isRecv) avail = nValid;
    else if (freeSlots >= FREE_W'(BW)) avail = CNT_W'(BW);
    else avail = CNT_W'(freeSlots);
  end

  assign totalNow  = (isRecv && atHead) ? ({1'b0, headCnt} + 1'b1) : ({1'b0, lenReg} + 1'b1);
  assign remaining = totalNow - pos;

  always_comb begin
    if (!busy) nMove = '0;
    else if ({{(POS_W-CNT_W){1'b0}}, avail} < remaining) nMove = avail;
    else nMove = remaining[CNT_W-1:0];
  end

  assign lastMove = busy && ({{(POS_W-CNT_W){1'b0}}, nMove} == remaining);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      isRecv  <= 1'b0;
      doneR   <= 1'b0;
      pos     <= '0;
      lenReg  <= '0;
      flowReg <= '0;
    end else begin
      doneR <= 1'b0;
      if (!busy) begin
        if (reqValid) begin
          busy    <= 1'b1;
          isRecv  <= reqRecv;
          pos     <= '0;
          lenReg  <= reqLen;
          flowReg <= reqFlow;
        end
      end else begin
        pos <= pos + {{(POS_W-CNT_W){1'b0}}, nMove};
        if (isRecv && atHead && (nMove != '0)) begin
          lenReg  <= headCnt;
          flowReg <= headFlow;
        end
        if (lastMove) begin
          busy  <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign reqAccept   = reqValid && !busy;
  assign reqFail     = reqValid && busy;
  assign done        = doneR;
  assign dataIdx     = atHead ? '0 : (pos[LEN_W-1:0] - 1'b1);
  assign strb.busy   = busy;
  assign strb.isRecv = isRecv;
  assign strb.atHead = atHead;
  assign strb.nMove  = nMove;
endmodule

// File: rtl/dmach_datapath.sv
module dmach_datapath
  import dmach_pkg::*;
#(
  parameter int BW     = 2,
  parameter int FLOW_W = 8,
  localparam int FLIT_W = FLOW_W + LEN_W
) (
  input  dmaStrobe_t           strb,
  input  logic [FLOW_W-1:0]    flowReg,
  input  logic [LEN_W-1:0]     lenReg,
  input  logic [BW*FLIT_W-1:0] rdData,
  input  logic [BW*FLIT_W-1:0] popData,
  output logic [BW-1:0]        pushValid,
  output logic [BW*FLIT_W-1:0] pushData,
  output logic [BW-1:0]        popTake,
  output logic [BW-1:0]        wrValid,
  output logic [BW*FLIT_W-1:0] wrData,
  output logic [FLOW_W-1:0]    headFlow,
  output logic [LEN_W-1:0]     headCnt
);
  logic [FLIT_W-1:0] headFlit;
  logic [FLIT_W-1:0] rdLane  [BW];
  logic [FLIT_W-1:0] popLane [BW];

  assign headFlit = {flowReg, lenReg};
  assign headFlow = popLane[0][FLIT_W-1 -: FLOW_W];
  assign headCnt  = popLane[0][LEN_W-1:0];

  for (genvar k = 0; k < BW; k++) begin : gLane
    logic [FLIT_W-1:0] sendFlit, rcvFlit;
    logic              sendMode, recvMode;

    assign rdLane[k]  = rdData[k*FLIT_W +: FLIT_W];
    assign popLane[k] = popData[k*FLIT_W +: FLIT_W];
    assign sendMode   = strb.busy && !strb.isRecv;
    assign recvMode   = strb.busy && strb.isRecv;

    // send side: head flit shifts payload lanes up by one
    if (k == 0) begin : gFirst
      assign sendFlit = strb.atHead ? headFlit : rdLane[0];
    end else begin : gRest
      assign sendFlit = strb.atHead ? rdLane[k-1] : rdLane[k];
    end

    // receive side: head flit is dropped, payload shifts down by one
    if (k == BW-1) begin : gTop
      assign rcvFlit = popLane[k];
    end else begin : gLow
      assign rcvFlit = strb.atHead ? popLane[k+1] : popLane[k];
    end

    assign pushData[k*FLIT_W +: FLIT_W] = sendFlit;
    assign wrData[k*FLIT_W +: FLIT_W]   = rcvFlit;
    assign pushValid[k] = sendMode && (CNT_W'(k) < strb.nMove);
    assign popTake[k]   = recvMode && (CNT_W'(k) < strb.nMove);
    assign wrValid[k]   = recvMode &&
                          ((strb.atHead ? CNT_W'(k + 1) : CNT_W'(k)) < strb.nMove);
  end
endmodule

// File: rtl/dmach_channel.sv
module dmach_channel
  import dmach_pkg::*;
#(
  parameter int BW_FLITS = 2,
  parameter int FLOW_W   = 8,
  parameter int FREE_W   = 4,
  localparam int FLIT_W  = FLOW_W + LEN_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       reqRecv,
  input  logic [FLOW_W-1:0]          reqFlow,
  input  logic [LEN_W-1:0]           reqLen,
  output logic                       reqAccept,
  output logic                       reqFail,
  output logic                       done,
  output logic [FLOW_W-1:0]          rxFlow,
  output logic [LEN_W-1:0]           dataIdx,
  input  logic [BW_FLITS*FLIT_W-1:0] rdData,
  output logic [BW_FLITS-1:0]        pushValid,
  output logic [BW_FLITS*FLIT_W-1:0] pushData,
  input  logic [FREE_W-1:0]          freeSlots,
  input  logic [BW_FLITS-1:0]        popValid,
  input  logic [BW_FLITS*FLIT_W-1:0] popData,
  output logic [BW_FLITS-1:0]        popTake,
  output logic [BW_FLITS-1:0]        wrValid,
  output logic [BW_FLITS*FLIT_W-1:0] wrData
);
  dmaStrobe_t        strb;
  logic [FLOW_W-1:0] flowReg, headFlow;
  logic [LEN_W-1:0]  lenReg, headCnt;

  dmach_ctrl #(.BW(BW_FLITS), .FREE_W(FREE_W), .FLOW_W(FLOW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRecv(reqRecv),
    .reqFlow(reqFlow), .reqLen(reqLen), .freeSlots(freeSlots),
    .popValid(popValid), .headFlow(headFlow), .headCnt(headCnt),
    .reqAccept(reqAccept), .reqFail(reqFail), .done(done), .strb(strb),
    .dataIdx(dataIdx), .flowReg(flowReg), .lenReg(lenReg)
  );

  dmach_datapath #(.BW(BW_FLITS), .FLOW_W(FLOW_W)) u_dp (
    .strb(strb), .flowReg(flowReg), .lenReg(lenReg), .rdData(rdData),
    .popData(popData), .pushValid(pushValid), .pushData(pushData),
    .popTake(popTake), .wrValid(wrValid), .wrData(wrData),
    .headFlow(headFlow), .headCnt(headCnt)
  );

  assign rxFlow = flowReg;
endmodule

// File: rtl/dmach_checker.sv
module dmach_checker #(
  parameter int BW     = 2,
  parameter int FLOW_W = 8,
  parameter int FREE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqRecv,
  input logic [FLOW_W-1:0] reqFlow,
  input logic              reqAccept,
  input logic              reqFail,
  input logic              done,
  input logic [BW-1:0]     pushValid,
  input logic [FLOW_W-1:0] lane0Flow,
  input logic [FREE_W-1:0] freeSlots,
  input logic [BW-1:0]     popValid,
  input logic [BW-1:0]     popTake,
  input logic [BW-1:0]     wrValid
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqAccept != reqFail)); // R4
  AST_NO_SPURIOUS_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!reqAccept && !reqFail)); // R4
  AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pushValid) <= int'(freeSlots)); // R3
  AST_PUSH_PACKED: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid & (pushValid + 1'b1)) == '0); // R3
  AST_HEAD_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqAccept && !reqRecv) && pushValid[0]) |-> (lane0Flow == $past(reqFlow))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !((|pushValid) && (|popTake))); // R5
  AST_TAKE_OFFERED: assert property (@(posedge clk) disable iff (!rstN)
    (popTake & ~popValid) == '0); // R8
  AST_WRITE_FROM_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wrValid) <= $countones(popTake)); // R5
endmodule

bind dmach_channel dmach_checker #(.BW(BW_FLITS), .FLOW_W(FLOW_W), .FREE_W(FREE_W)) u_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRecv(reqRecv),
  .reqFlow(reqFlow), .reqAccept(reqAccept), .reqFail(reqFail), .done(done),
  .pushValid(pushValid), .lane0Flow(pushData[FLOW_W+15 -: FLOW_W]),
  .freeSlots(freeSlots), .popValid(popValid), .popTake(popTake), .wrValid(wrValid)
);

// File: tb/dmach_channel_bench.sv
module dmach_channel_bench;
  localparam int PERIOD = 10;
  localparam int BW     = 2;
  localparam int FLOW_W = 8;
  localparam int FREE_W = 4;
  localparam int FLIT_W = FLOW_W + 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic              reqValid = 1'b0, reqRecv = 1'b0;
  logic [FLOW_W-1:0] reqFlow = '0;
  logic [15:0]       reqLen = '0;
  logic              reqAccept, reqFail, done;
  logic [FLOW_W-1:0] rxFlow;
  logic [15:0]       dataIdx;
  logic [BW*FLIT_W-1:0] rdData, pushData, wrData;
  logic [BW*FLIT_W-1:0] popData = '0;
  logic [BW-1:0]     pushValid, popTake, wrValid;
  logic [BW-1:0]     popValid = '0;
  logic [FREE_W-1:0] freeSlots = '0;

  dmach_channel #(.BW_FLITS(BW), .FLOW_W(FLOW_W), .FREE_W(FREE_W)) u_dmach_channel (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRecv(reqRecv),
    .reqFlow(reqFlow), .reqLen(reqLen), .reqAccept(reqAccept), .reqFail(reqFail),
    .done(done), .rxFlow(rxFlow), .dataIdx(dataIdx), .rdData(rdData),
    .pushValid(pushValid), .pushData(pushData), .freeSlots(freeSlots),
    .popValid(popValid), .popData(popData), .popTake(popTake),
    .wrValid(wrValid), .wrData(wrData)
  );

  logic [FLIT_W-1:0] mem [64];
  always_comb begin
    for (int j = 0; j < BW; j++) rdData[j*FLIT_W +: FLIT_W] = mem[(int'(dataIdx) + j) % 64];
  end

  int vectors = 0, misses = 0, cyc = 0;
  bit ended = 1'b0;

  // reference model state
  bit mBusy = 0, mRecv = 0, mDonePend = 0, lastRecv = 0, sendAtHead = 0, rxAtHead = 0;
  logic [FLIT_W-1:0] sendQ[$];
  logic [FLIT_W-1:0] rxStream[$];
  int rxLeft = 0, rxWrIdx = 0, freeFix = -1, offerFix = -1, busyCyc = 0;
  logic [FLOW_W-1:0] rxExpFlow = '0;

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit rv, input bit rr, input logic [FLOW_W-1:0] rf, input logic [15:0] rl);
    int freeNow, offer, n, take, wrN;
    bit accept;
    logic [BW-1:0] expPush, expTake, expWr;
    @(negedge clk);
    cyc++;
    freeNow = (freeFix >= 0) ? freeFix : (cyc * 7 + 3) % 5;
    offer = (offerFix >= 0) ? offerFix : (((cyc % 3) == 0) ? 1 : 2);
    offer = imin(imin(offer, rxStream.size()), BW);
    freeSlots = FREE_W'(freeNow);
    popValid = '0;
    popData = '0;
    for (int k = 0; k < offer; k++) begin
      popValid[k] = 1'b1;
      popData[k*FLIT_W +: FLIT_W] = rxStream[k];
    end
    reqValid = rv; reqRecv = rr; reqFlow = rf; reqLen = rl;
    #1;
    accept = rv && !mBusy;
    chk("R1", "reqAccept", longint'(reqAccept), longint'(accept));
    chk("R4", "reqFail", longint'(reqFail), longint'(rv && mBusy));
    chk("R6", "done", longint'(done), longint'(mDonePend));
    if (mDonePend && lastRecv) chk("R5", "rxFlow", longint'(rxFlow), longint'(rxExpFlow));
    if (accept) chk("R1", "no push on accept", longint'(pushValid), 0);
    expPush = '0; n = 0;
    if (mBusy && !mRecv) begin
      n = imin(imin(BW, freeNow), sendQ.size());
      for (int k = 0; k < n; k++) expPush[k] = 1'b1;
    end
    chk("R3", "pushValid", longint'(pushValid), longint'(expPush));
    for (int k = 0; k < n; k++)
      chk((k == 0 && sendAtHead) ? "R2" : "R3", "pushData",
          longint'(pushData[k*FLIT_W +: FLIT_W]), longint'(sendQ[k]));
    take = 0; wrN = 0; expTake = '0; expWr = '0;
    if (mBusy && mRecv && offer > 0) begin
      if (rxAtHead) begin
        rxLeft = int'(rxStream[0][15:0]) + 1;
        rxExpFlow = rxStream[0][FLIT_W-1 -: FLOW_W];
      end
      take = imin(offer, rxLeft);
      for (int k = 0; k < take; k++) expTake[k] = 1'b1;
      wrN = rxAtHead ? take - 1 : take;
      for (int j = 0; j < wrN; j++) expWr[j] = 1'b1;
    end
    chk((offer > take) ? "R8" : "R5", "popTake", longint'(popTake), longint'(expTake));
    chk("R5", "wrValid", longint'(wrValid), longint'(expWr));
    for (int j = 0; j < wrN; j++)
      chk("R5", "wrData", longint'(wrData[j*FLIT_W +: FLIT_W]),
          longint'(rxStream[rxAtHead ? j + 1 : j]));
    if (wrN > 0) chk("R5", "dataIdx", longint'(dataIdx), longint'(rxWrIdx));
    // clock edge
    mDonePend = 0;
    if (n > 0) begin
      repeat (n) void'(sendQ.pop_front());
      sendAtHead = 0;
      if (sendQ.size() == 0) begin mBusy = 0; mDonePend = 1; lastRecv = 0; end
    end
    if (take > 0) begin
      repeat (take) void'(rxStream.pop_front());
      rxWrIdx += wrN;
      rxLeft -= take;
      rxAtHead = 0;
      if (rxLeft == 0) begin mBusy = 0; mDonePend = 1; lastRecv = 1; end
    end
    if (accept) begin
      mBusy = 1;
      mRecv = rr;
      if (!rr) begin
        sendQ.delete();
        sendQ.push_back({rf, rl});
        for (int i = 0; i < int'(rl); i++) sendQ.push_back(mem[i % 64]);
        sendAtHead = 1;
      end else begin
        rxAtHead = 1;
        rxWrIdx = 0;
      end
    end
  endtask

  task automatic runOut();
    busyCyc = 0;
    while (mBusy) begin
      step(busyCyc < 2, 1'b0, 8'hC4, 16'd9);  // R4: refused requests mid-transfer
      busyCyc++;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = FLIT_W'(24'h0B0000 + i * 24'h000123);
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset reqAccept", longint'(reqAccept), 0);
    chk("R6", "reset done", longint'(done), 0);
    chk("R3", "reset pushValid", longint'(pushValid), 0);
    chk("R8", "reset popTake", longint'(popTake), 0);
    rstN = 1'b1;

    // send with a varying free-slot pattern
    freeFix = -1;
    step(1'b1, 1'b0, 8'h3A, 16'd5);
    runOut();
    // zero length, request placed in the done cycle
    freeFix = 2;
    step(1'b1, 1'b0, 8'h11, 16'd0);
    runOut();
    chk("R7", "zero-length send cycles", longint'(busyCyc), 1);
    // one free slot per cycle
    freeFix = 1;
    step(1'b1, 1'b0, 8'h7E, 16'd3);
    runOut();
    chk("R3", "single-lane send cycles", longint'(busyCyc), 4);
    // more room than lanes
    freeFix = 4;
    step(1'b1, 1'b0, 8'h22, 16'd7);
    runOut();
    chk("R3", "full-width send cycles", longint'(busyCyc), 4);

    // receive: two packets back to back in the stream
    rxStream.push_back({8'h55, 16'd4});
    for (int i = 0; i < 4; i++) rxStream.push_back(FLIT_W'(24'h0A0000 + i));
    rxStream.push_back({8'h99, 16'd2});
    rxStream.push_back(24'h0C0001);
    rxStream.push_back(24'h0C0002);
    rxStream.push_back({8'h66, 16'd0});
    rxStream.push_back({8'h77, 16'd1});
    offerFix = -1;
    step(1'b1, 1'b1, 8'h00, 16'd0);
    runOut();
    step(1'b1, 1'b1, 8'h00, 16'd0);
    runOut();
    offerFix = 2;
    step(1'b1, 1'b1, 8'h00, 16'd0);
    runOut();
    chk("R7", "zero-length receive cycles", longint'(busyCyc), 1);
    // idle with flits on offer: nothing taken
    repeat (3) step(1'b0, 1'b0, 8'h00, 16'd0);
    chk("R8", "stream left untouched", longint'(rxStream.size()), 1);

    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!ended) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule